// File: doc/BRIEF.md
# Banked Low-Power Synchronous RAM

This block presents one logical synchronous RAM of 4096 words by 4 bits, with one write port and one read port on a single clock. Internally the storage is split into four physical banks. In the default layout each bank holds a contiguous quarter of the address space as 1024 words by 4 bits. The two top address bits pick the bank, and the ten low bits address the word inside it. On any cycle only the addressed bank has its write or read clock enable raised, so the three idle banks draw no clocking power.

The user write and read enables become per-bank write and read clock enables. An optional user clock enable is ANDed with them and with the bank select. The read data comes back one cycle after the read request, through a multiplexer. The select for that multiplexer is captured together with the read, so it always points at the bank that was actually read. A parameter switches to the alternative layout. There, four banks of 4096 words by 1 bit each store one data bit, and every bank is enabled on every access. Both layouts give identical contents and timing at the ports.

Top module: `bankram_top`

## Requirements
- R1: A word written to address A (12 bits) with wrEn=1 and userCe=1 is returned on rdData exactly one clock after a cycle with rdEn=1, userCe=1 and rdAddr=A, for every one of the 4096 addresses.
- R2: In the default (address-range) layout, bit b of bankWrCe is 1 only when userCe=1, wrEn=1 and wrAddr[11:10]=b. Likewise, bit b of bankRdCe is 1 only when userCe=1, rdEn=1 and rdAddr[11:10]=b. All other bits are 0.
- R3: In the default layout, at most one bit of bankWrCe and at most one bit of bankRdCe are 1 in any cycle.
- R4: With userCe=0, all bank enables are 0, no write takes place, and rdData keeps its value.
- R5: With rdEn=0, rdData keeps its previous value. With wrEn=0, memory contents are unchanged.
- R6: When a read and a write address the same word in the same cycle, the read returns the data held before the write. The new data is visible to the next read.
- R7: Back-to-back reads from different banks each return the word of their own address. Data held by a bank that was not read never reaches rdData.
- R8: With VERTICAL=1, all four bits of bankWrCe are 1 on every enabled write, and all four bits of bankRdCe are 1 on every enabled read. The returned data equals the data of the default layout for the same stimulus.
- R9: After reset, rdData is 0 until the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Active-low synchronous reset of output and select registers |
| userCe | input | 1 | Global clock enable, ANDed into every bank enable |
| wrEn | input | 1 | Write request |
| wrAddr | input | 12 | Write word address |
| wrData | input | 4 | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | 12 | Read word address |
| rdData | output | 4 | Read data, one cycle after the request |
| bankWrCe | output | 4 | Per-bank write clock enables |
| bankRdCe | output | 4 | Per-bank read clock enables |

## Verification
A write and a read can fall in the same cycle. They may target the same word, or different banks, so that two banks are active at once. The bench provokes the same-word case by reading an address while writing new data to it. It judges that the read shows the old word and that a following read shows the new one. Two instances, one per layout, run on identical stimulus. Every returned word is compared against a bench-side model, and the bank enables are checked against the decoded top address bits.

// File: rtl/bankram_pkg.sv
package bankram_pkg;
  localparam int BANK_COUNT = 4;
  localparam int SEL_W = $clog2(BANK_COUNT);

  typedef struct packed {
    logic [BANK_COUNT-1:0] wrCe;
    logic [BANK_COUNT-1:0] rdCe;
    logic [SEL_W-1:0]      outSel;
  } strobe_t;
endpackage

// File: rtl/bankram_ctrl.sv
module bankram_ctrl
  import bankram_pkg::*;
#(
  parameter int DEPTH    = 4096,
  parameter bit VERTICAL = 1'b0,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          userCe,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output strobe_t       strb
);
  logic [SEL_W-1:0] wrSel;
  logic [SEL_W-1:0] rdSel;
  logic [SEL_W-1:0] outSelQ;
  logic             wrGo;
  logic             rdGo;

  assign wrSel = wrAddr[AW-1 -: SEL_W];
  assign rdSel = rdAddr[AW-1 -: SEL_W];
  assign wrGo  = userCe & wrEn;
  assign rdGo  = userCe & rdEn;

  generate
    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_ce
      if (VERTICAL) begin : g_vert
        assign strb.wrCe[b] = wrGo;
        assign strb.rdCe[b] = rdGo;
      end else begin : g_horz
        assign strb.wrCe[b] = wrGo & (wrSel == SEL_W'(b));
        assign strb.rdCe[b] = rdGo & (rdSel == SEL_W'(b));
      end
    end
  endgenerate

  // select travels with the read so it matches the one-cycle latency
  always_ff @(posedge clk) begin
    if (!rstN)     outSelQ <= '0;
    else if (rdGo) outSelQ <= rdSel;
  end
  assign strb.outSel = outSelQ;

  AST_WR_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !VERTICAL |-> $onehot0(strb.wrCe)); // R3
  AST_RD_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !VERTICAL |-> $onehot0(strb.rdCe)); // R3
  AST_CE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !userCe |-> (strb.wrCe == '0 && strb.rdCe == '0)); // R4
  AST_VERT_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (VERTICAL && userCe && wrEn) |-> (&strb.wrCe)); // R8
  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (userCe && rdEn) |=> (strb.outSel == $past(rdSel))); // R7
  AST_SEL_WR_TIED: assert property (@(posedge clk) disable iff (!rstN)
    (!VERTICAL && userCe && wrEn) |-> strb.wrCe[wrSel]); // R2
endmodule

// File: rtl/bankram_dp.sv
module bankram_dp
  import bankram_pkg::*;
#(
  parameter int DEPTH    = 4096,
  parameter int WIDTH    = 4,
  parameter bit VERTICAL = 1'b0,
  localparam int BD      = VERTICAL ? DEPTH : DEPTH / BANK_COUNT,
  localparam int BW      = VERTICAL ? WIDTH / BANK_COUNT : WIDTH,
  localparam int BAW     = $clog2(BD)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BAW-1:0]   wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [BAW-1:0]   rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [BW-1:0] bankQ [BANK_COUNT];

  generate
    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
      logic [BW-1:0] mem [BD];
      logic [BW-1:0] q;
      logic [BW-1:0] din;
      if (VERTICAL) begin : g_vslice
        assign din = wrData[b*BW +: BW];
      end else begin : g_hslice
        assign din = wrData;
      end
      always_ff @(posedge clk) begin
        if (strb.wrCe[b]) mem[wrAddr] <= din;
      end
      // nonblocking read of mem gives the pre-write word
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (strb.rdCe[b])  q <= mem[rdAddr];
      end
      assign bankQ[b] = q;
    end

    if (VERTICAL) begin : g_vout
      for (genvar b = 0; b < BANK_COUNT; b++) begin : g_cat
        assign rdData[b*BW +: BW] = bankQ[b];
      end
    end else begin : g_hout
      assign rdData = bankQ[strb.outSel];
    end
  endgenerate

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCe == '0) |=> $stable(rdData)); // R5
endmodule

// File: rtl/bankram_top.sv
module bankram_top
  import bankram_pkg::*;
#(
  parameter int DEPTH    = 4096,
  parameter int WIDTH    = 4,
  parameter bit VERTICAL = 1'b0,
  localparam int AW      = $clog2(DEPTH),
  localparam int BAW     = VERTICAL ? AW : AW - SEL_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  userCe,
  input  logic                  wrEn,
  input  logic [AW-1:0]         wrAddr,
  input  logic [WIDTH-1:0]      wrData,
  input  logic                  rdEn,
  input  logic [AW-1:0]         rdAddr,
  output logic [WIDTH-1:0]      rdData,
  output logic [BANK_COUNT-1:0] bankWrCe,
  output logic [BANK_COUNT-1:0] bankRdCe
);
  strobe_t strb;

  bankram_ctrl #(.DEPTH(DEPTH), .VERTICAL(VERTICAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .userCe(userCe),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .strb(strb)
  );

  bankram_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .VERTICAL(VERTICAL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr[BAW-1:0]), .wrData(wrData),
    .rdAddr(rdAddr[BAW-1:0]), .rdData(rdData)
  );

  assign bankWrCe = strb.wrCe;
  assign bankRdCe = strb.rdCe;
endmodule

// File: tb/bankram_top_test.sv
module bankram_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        userCe = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [11:0] rdAddr = '0;
  logic [3:0]  wrData = '0;
  logic [3:0]  rdH, rdV;
  logic [3:0]  wceH, rceH, wceV, rceV;
  logic [3:0]  model [4096];
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bankram_top #(.VERTICAL(1'b0)) uut (
    .clk(clk), .rstN(rstN), .userCe(userCe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdH),
    .bankWrCe(wceH), .bankRdCe(rceH));

  bankram_top #(.VERTICAL(1'b1)) uutV (
    .clk(clk), .rstN(rstN), .userCe(userCe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdV),
    .bankWrCe(wceV), .bankRdCe(rceV));

  function automatic logic [3:0] pat(int a, int k);
    return 4'((a * 7 + (a >> 5) + k) & 15);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, check enables, clock, land on next negedge
  task automatic cyc(bit ce, bit we, int wa, logic [3:0] wd, bit re, int ra);
    logic [3:0] ew, er;
    userCe = ce; wrEn = we; wrAddr = 12'(wa); wrData = wd;
    rdEn = re; rdAddr = 12'(ra);
    #1;
    ew = (ce && we) ? 4'(1 << (wa >> 10)) : 4'h0;
    er = (ce && re) ? 4'(1 << (ra >> 10)) : 4'h0;
    chk("R2 wrCe", wceH, ew);
    chk("R2 rdCe", rceH, er);
    chk("R8 vert wrCe", wceV, (ce && we) ? 4'hF : 4'h0);
    chk("R8 vert rdCe", rceV, (ce && re) ? 4'hF : 4'h0);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 30000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R9 reset H", rdH, 4'h0);
    chk("R9 reset V", rdV, 4'h0);

    // R1 R2 R3: fill every word
    for (int a = 0; a < 4096; a++) begin
      cyc(1, 1, a, pat(a, 0), 0, 0);
      model[a] = pat(a, 0);
    end
    // R1 R7: read every word, consecutive reads cross banks via stride
    for (int i = 0; i < 4096; i++) begin
      int a = ((i & 3) << 10) | (i >> 2);
      cyc(1, 0, 0, 0, 1, a);
      chk("R1/R7 read H", rdH, model[a]);
      chk("R8 read V", rdV, model[a]);
    end

    // R6: same-address read and write
    for (int a = 0; a < 4096; a += 511) begin
      cyc(1, 1, a, pat(a, 9), 1, a);
      chk("R6 old data H", rdH, model[a]);
      chk("R6 old data V", rdV, model[a]);
      model[a] = pat(a, 9);
      cyc(1, 0, 0, 0, 1, a);
      chk("R6 new data H", rdH, model[a]);
      chk("R6 new data V", rdV, model[a]);
    end

    // R2: write and read in different banks in one cycle
    cyc(1, 1, 12'h005, 4'hA, 1, 12'hC07);
    chk("R2 cross read H", rdH, model[12'hC07]);
    model[12'h005] = 4'hA;

    // R4: userCe low blocks write and holds output
    cyc(1, 0, 0, 0, 1, 12'h801);
    chk("R4 prep", rdH, model[12'h801]);
    cyc(0, 1, 12'h801, ~model[12'h801], 1, 12'h005);
    chk("R4 hold H", rdH, model[12'h801]);
    chk("R4 hold V", rdV, model[12'h801]);
    cyc(1, 0, 0, 0, 1, 12'h801);
    chk("R4 no write H", rdH, model[12'h801]);

    // R5: rdEn low holds output, wrEn low writes nothing
    cyc(1, 0, 12'h402, ~model[12'h402], 0, 12'h402);
    chk("R5 hold H", rdH, model[12'h801]);
    chk("R5 hold V", rdV, model[12'h801]);
    cyc(1, 0, 0, 0, 1, 12'h402);
    chk("R5 no write H", rdH, model[12'h402]);
    chk("R5 no write V", rdV, model[12'h402]);

    // R7: other bank rewritten, output stays on the bank read
    cyc(1, 1, 12'h002, ~model[12'h402], 0, 0);
    model[12'h002] = ~model[12'h402];
    chk("R7 stale bank H", rdH, model[12'h402]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule